// File: doc/BRIEF.md
# Four-Channel Periodic Interrupt Timer

This block holds four independent down-counting timers behind a small register port. Each channel counts down from a programmed value and, on passing zero, raises its own flag and starts over from the programmed value. No software action is needed between periods. Software programs a channel with three writes: the reload value, then the control word that starts it, then a write-one-to-clear of the flag in the interrupt handler. A global disable bit halts all channels at once. Reset leaves the global disable bit set.

Any channel other than channel 0 can be chained to the channel below it. A chained channel then counts periods of its neighbour instead of clock cycles, so a pair of channels acts as one wide timer. The register port is single-cycle. A write takes effect at the clock edge where the write enable is high. A read returns data combinationally from the address.

Register layout. The global control word is at 0x000, and bit 1 is the global disable. Channel n occupies 0x100 + 0x10*n. Within a channel, +0x0 is the reload value, +0x4 the current count (read-only), +0x8 the control word and +0xC the flag word. In the control word, bit 0 starts the channel, bit 1 unmasks its interrupt and bit 2 chains it to channel n-1. The flag is bit 0 of the flag word.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, the global control word at 0x000 reads 0x2 (global disable bit 1 set). Every channel word reads 0 and every irq output is low.
- R2: While global disable (bit 1 of 0x000) is set, no channel changes its count or sets its flag. A channel enabled while global disable is set does not start.
- R3: One clock after a channel sees its run bit (control bit 0) set with global disable clear, coming from the stopped state, its current count (+0x4) equals the reload value. After that it drops by one per clock.
- R4: A running channel whose count is zero on an active step sets its flag (bit 0 of +0xC) and reloads from the reload value. The period is therefore reload value + 1 clocks, and it repeats.
- R5: irq[n] is high exactly when channel n's flag is set and its interrupt unmask bit (control bit 1) is set.
- R6: Writing 1 to bit 0 of a channel's flag word clears the flag. Writing 0 leaves it unchanged.
- R7: Writing the reload value while a channel runs does not change the current count or the period in progress. The new value is used at the next reload.
- R8: Clearing and then setting the run bit restarts the count from the reload value in force at that time.
- R9: A channel n>0 with its chain bit (control bit 2) set steps once per reload of channel n-1, not once per clock.
- R10: Channel 0 ignores its chain bit and steps once per clock.
- R11: When a flag set and a write-one-to-clear of that flag fall in the same clock, the flag ends set.
- R12: The current count word (+0x4) is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Per-channel interrupt, flag AND unmask |

## Verification
The function most likely to collide is the wrap of a channel, which sets its flag, with a software write-one-to-clear of that same flag in the same clock. The bench runs a channel with a two-clock period. It clears the flag once in a cycle with no wrap and expects the flag to read 0. It then clears again in the exact cycle where the next wrap lands and expects the flag to read 1. A second coincidence is a reload-value write in the middle of a period. The bench checks that the count still follows the old value down to zero and that only the reload then picks up the new value.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
    // word offsets inside a channel window
    localparam int OFS_RELOAD = 'h0;
    localparam int OFS_COUNT  = 'h4;
    localparam int OFS_CTRL   = 'h8;
    localparam int OFS_FLAG   = 'hC;

    // bit positions
    localparam int GDIS_BIT  = 1;
    localparam int RUN_BIT   = 0;
    localparam int UNMASK_BIT = 1;
    localparam int CHAIN_BIT = 2;
    localparam int CTRL_W    = 3;
    localparam int FLAG_BIT  = 0;

    typedef enum logic [0:0] {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/ttb_channel.sv
`timescale 1ns/1ps
module ttb_channel
    import tick_timer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          step_i,
    input  logic          clr_i,
    input  logic [CW-1:0] reload_i,
    output logic [CW-1:0] cnt_o,
    output logic          flag_o,
    output logic          wrap_o
);
    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          flag_q;
    logic          at_zero;

    assign at_zero = (cnt_q == '0);
    // reload event: running, stepping and sitting on zero
    assign wrap_o  = (st_q == CH_COUNT) && run_i && step_i && at_zero;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // transitions: IDLE -> COUNT on start, COUNT -> IDLE on stop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (run_i)  st_d = CH_COUNT;
            CH_COUNT: if (!run_i) st_d = CH_IDLE;
            default:  st_d = CH_IDLE;
        endcase
    end

    // datapath and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    if (run_i) cnt_q <= reload_i;
                end
                CH_COUNT: begin
                    if (run_i && step_i)
                        cnt_q <= at_zero ? reload_i : cnt_q - CW'(1);
                end
                default: cnt_q <= cnt_q;
            endcase
            // a set in the same cycle as a clear wins
            if (wrap_o)     flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/ttb_regfile.sv
`timescale 1ns/1ps
module ttb_regfile
    import tick_timer_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CW        = 32,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int CH_BASE   = 'h100,
    parameter int CH_STRIDE = 'h10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr_i,
    input  logic                    we_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           rdata_o,
    input  logic [NCH-1:0][CW-1:0]  cnt_i,
    input  logic [NCH-1:0]          flag_i,
    output logic                    gdis_o,
    output logic [NCH-1:0][CW-1:0]  reload_o,
    output logic [NCH-1:0]          run_o,
    output logic [NCH-1:0]          unmask_o,
    output logic [NCH-1:0]          chain_o,
    output logic [NCH-1:0]          clr_o
);
    logic                          gdis_q;
    logic [NCH-1:0][CW-1:0]        reload_q;
    logic [NCH-1:0][CTRL_W-1:0]    ctrl_q;
    logic [NCH-1:0]                hit_rl, hit_cn, hit_ct, hit_fl;
    logic                          hit_g;

    assign hit_g = (addr_i == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        localparam logic [AW-1:0] BASE = AW'(CH_BASE + CH_STRIDE * n);
        assign hit_rl[n]   = (addr_i == BASE + AW'(OFS_RELOAD));
        assign hit_cn[n]   = (addr_i == BASE + AW'(OFS_COUNT));
        assign hit_ct[n]   = (addr_i == BASE + AW'(OFS_CTRL));
        assign hit_fl[n]   = (addr_i == BASE + AW'(OFS_FLAG));
        assign clr_o[n]    = we_i && hit_fl[n] && wdata_i[FLAG_BIT];
        assign run_o[n]    = ctrl_q[n][RUN_BIT];
        assign unmask_o[n] = ctrl_q[n][UNMASK_BIT];
        assign chain_o[n]  = ctrl_q[n][CHAIN_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdis_q   <= 1'b1;
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (we_i) begin
            if (hit_g) gdis_q <= wdata_i[GDIS_BIT];
            for (int n = 0; n < NCH; n++) begin
                if (hit_rl[n]) reload_q[n] <= wdata_i[CW-1:0];
                if (hit_ct[n]) ctrl_q[n]   <= wdata_i[CTRL_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_g) rdata_o[GDIS_BIT] = gdis_q;
        for (int n = 0; n < NCH; n++) begin
            if (hit_rl[n]) rdata_o = DW'(reload_q[n]);
            if (hit_cn[n]) rdata_o = DW'(cnt_i[n]);
            if (hit_ct[n]) rdata_o = DW'(ctrl_q[n]);
            if (hit_fl[n]) rdata_o = DW'(flag_i[n]);
        end
    end

    assign gdis_o   = gdis_q;
    assign reload_o = reload_q;
endmodule

// File: rtl/tick_timer_bank.sv
`timescale 1ns/1ps
module tick_timer_bank #(
    parameter int NCH       = 4,
    parameter int CW        = 32,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int CH_BASE   = 'h100,
    parameter int CH_STRIDE = 'h10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    logic                   gdis;
    logic [NCH-1:0][CW-1:0] ch_reload;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0]         ch_run, ch_unmask, ch_chain, ch_clr;
    logic [NCH-1:0]         ch_flag, ch_wrap, ch_step, ch_go;

    ttb_regfile #(
        .NCH(NCH), .CW(CW), .AW(AW), .DW(DW),
        .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .cnt_i    (ch_cnt),
        .flag_i   (ch_flag),
        .gdis_o   (gdis),
        .reload_o (ch_reload),
        .run_o    (ch_run),
        .unmask_o (ch_unmask),
        .chain_o  (ch_chain),
        .clr_o    (ch_clr)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_go[n] = ch_run[n] && !gdis;
        if (n == 0) begin : g_head
            assign ch_step[n] = 1'b1;
        end else begin : g_link
            assign ch_step[n] = ch_chain[n] ? ch_wrap[n-1] : 1'b1;
        end
        ttb_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (ch_go[n]),
            .step_i   (ch_step[n]),
            .clr_i    (ch_clr[n]),
            .reload_i (ch_reload[n]),
            .cnt_o    (ch_cnt[n]),
            .flag_o   (ch_flag[n]),
            .wrap_o   (ch_wrap[n])
        );
    end

    assign irq = ch_flag & ch_unmask;
endmodule

// File: rtl/tick_timer_bank_chk.sv
`timescale 1ns/1ps
module tick_timer_bank_chk #(
    parameter int NCH = 4,
    parameter int CW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         irq,
    input logic                   gdis,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0]         unmask,
    input logic [NCH-1:0][CW-1:0] reload,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0]         flag
);
    for (genvar i = 0; i < NCH; i++) begin : g_prop
        // R2: global disable freezes every count
        a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            gdis |=> $stable(cnt[i]));
        // R4: a flag only appears after the count sat on zero
        a_r4_wrap_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> ($past(cnt[i]) == '0));
        // R4: the wrap reloads from the reload value in force
        a_r4_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> (cnt[i] == $past(reload[i])));
        // R5: a masked channel never drives its interrupt
        a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !unmask[i] |-> !irq[i]);
        // R8: a stopped channel holds its count
        a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |=> $stable(cnt[i]));
    end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .gdis   (gdis),
    .run    (ch_run),
    .unmask (ch_unmask),
    .reload (ch_reload),
    .cnt    (ch_cnt),
    .flag   (ch_flag)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [11:0] ca(input int n, input int ofs);
        return 12'(32'h100 + 32'h10 * n + ofs);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic chk_rd(input string what, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.1;
        chk(what, bus_rdata, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk_rd("R1 global control", 12'h000, 32'h2);
        chk("R1 irq", 32'(irq), 32'h0);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk_rd("R1 reload", ca(n, 'h0), 0);
            chk_rd("R1 count",  ca(n, 'h4), 0);
            chk_rd("R1 ctrl",   ca(n, 'h8), 0);
            chk_rd("R1 flag",   ca(n, 'hC), 0);
        end
    endtask

    task automatic t_global_disable();
        do_reset();
        wr(ca(0, 'h0), 3);
        wr(ca(0, 'h8), 3);
        repeat (8) @(negedge clk);
        chk_rd("R2 count held while disabled", ca(0, 'h4), 0);
        chk_rd("R2 no flag while disabled", ca(0, 'hC), 0);
        wr(12'h000, 0);                       // edge k
        @(negedge clk);                       // k+1: loaded
        chk_rd("R3 load on start", ca(0, 'h4), 3);
        repeat (2) @(negedge clk);            // k+3
        chk_rd("R3 count step", ca(0, 'h4), 1);
        wr(12'h000, 32'h2);                   // k+4: count 0, then frozen
        repeat (5) @(negedge clk);
        chk_rd("R2 frozen count", ca(0, 'h4), 0);
        chk_rd("R2 frozen flag", ca(0, 'hC), 0);
    endtask

    task automatic t_period();
        do_reset();
        wr(12'h000, 0);
        wr(ca(1, 'h0), 5);
        wr(ca(1, 'h8), 3);                    // edge k
        @(negedge clk);
        chk_rd("R3 count after start", ca(1, 'h4), 5);
        repeat (5) @(negedge clk);            // k+6
        chk_rd("R4 count at zero", ca(1, 'h4), 0);
        chk_rd("R4 no early flag", ca(1, 'hC), 0);
        @(negedge clk);                       // k+7
        chk_rd("R4 flag on wrap", ca(1, 'hC), 1);
        chk_rd("R4 reload on wrap", ca(1, 'h4), 5);
        chk("R5 irq unmasked", 32'(irq), 32'h2);
        wr(ca(1, 'hC), 1);                    // k+8
        chk_rd("R6 cleared", ca(1, 'hC), 0);
        chk("R5 irq after clear", 32'(irq), 32'h0);
        repeat (4) @(negedge clk);            // k+12
        chk_rd("R4 second period no flag", ca(1, 'hC), 0);
        @(negedge clk);                       // k+13
        chk_rd("R4 second period flag", ca(1, 'hC), 1);
    endtask

    task automatic t_mask_and_clear();
        do_reset();
        wr(12'h000, 0);
        wr(ca(2, 'h0), 1);
        wr(ca(2, 'h8), 1);                    // edge k, flag at k+3
        repeat (3) @(negedge clk);
        chk_rd("R5 flag set while masked", ca(2, 'hC), 1);
        chk("R5 masked irq low", 32'(irq), 32'h0);
        wr(ca(2, 'h8), 0);                    // stop
        wr(ca(2, 'hC), 0);
        chk_rd("R6 write zero keeps flag", ca(2, 'hC), 1);
        wr(ca(2, 'h8), 2);                    // unmask, still stopped
        chk("R5 irq follows unmask", 32'(irq), 32'h4);
        wr(ca(2, 'hC), 1);
        chk_rd("R6 write one clears", ca(2, 'hC), 0);
        chk("R5 irq low after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_reload_rewrite();
        do_reset();
        wr(12'h000, 0);
        wr(ca(3, 'h0), 9);
        wr(ca(3, 'h8), 1);                    // edge k
        repeat (3) @(negedge clk);            // k+3: 7
        wr(ca(3, 'h0), 2);                    // k+4: 6
        chk_rd("R7 count undisturbed", ca(3, 'h4), 6);
        repeat (6) @(negedge clk);            // k+10
        chk_rd("R7 old period kept", ca(3, 'hC), 0);
        @(negedge clk);                       // k+11
        chk_rd("R7 flag on old period", ca(3, 'hC), 1);
        chk_rd("R7 new value at reload", ca(3, 'h4), 2);
        wr(ca(3, 'h8), 0);                    // k+12 stop
        wr(ca(3, 'h0), 4);
        wr(ca(3, 'h8), 1);                    // restart
        @(negedge clk);
        chk_rd("R8 restart from reload", ca(3, 'h4), 4);
    endtask

    task automatic t_chain();
        do_reset();
        wr(12'h000, 0);
        wr(ca(0, 'h0), 2);
        wr(ca(1, 'h0), 1);
        wr(ca(1, 'h8), 5);                    // chained + running
        repeat (4) @(negedge clk);
        chk_rd("R9 chained holds without events", ca(1, 'h4), 1);
        wr(ca(0, 'h8), 1);                    // edge k
        repeat (4) @(negedge clk);            // k+4: first wrap of ch0
        chk_rd("R9 ch0 wrapped", ca(0, 'hC), 1);
        chk_rd("R9 chained stepped once", ca(1, 'h4), 0);
        repeat (2) @(negedge clk);            // k+6
        chk_rd("R9 chained no flag yet", ca(1, 'hC), 0);
        @(negedge clk);                       // k+7
        chk_rd("R9 chained flag", ca(1, 'hC), 1);
        chk_rd("R9 chained reload", ca(1, 'h4), 1);
    endtask

    task automatic t_head_chain_ignored();
        do_reset();
        wr(12'h000, 0);
        wr(ca(0, 'h0), 2);
        wr(ca(0, 'h8), 5);                    // edge k, flag at k+4
        repeat (3) @(negedge clk);
        chk_rd("R10 ch0 no early flag", ca(0, 'hC), 0);
        @(negedge clk);
        chk_rd("R10 ch0 counts per clock", ca(0, 'hC), 1);
    endtask

    task automatic t_set_clear_collide();
        do_reset();
        wr(12'h000, 0);
        wr(ca(0, 'h0), 1);
        wr(ca(0, 'h8), 1);                    // edge k, wraps k+3, k+5
        repeat (3) @(negedge clk);
        chk_rd("R11 first wrap", ca(0, 'hC), 1);
        wr(ca(0, 'hC), 1);                    // k+4 no wrap
        chk_rd("R11 plain clear", ca(0, 'hC), 0);
        wr(ca(0, 'hC), 1);                    // k+5 wrap and clear
        chk_rd("R11 set wins over clear", ca(0, 'hC), 1);
    endtask

    task automatic t_count_readonly();
        do_reset();
        wr(12'h000, 0);
        wr(ca(2, 'h0), 7);
        wr(ca(2, 'h4), 32'h1234);
        chk_rd("R12 count ignores write", ca(2, 'h4), 0);
        chk_rd("R12 reload untouched", ca(2, 'h0), 7);
        wr(ca(2, 'h8), 1);                    // edge k
        wr(ca(2, 'h4), 32'h55);               // k+1 load
        chk_rd("R12 running count ignores write", ca(2, 'h4), 7);
    endtask

    initial begin
        t_reset();
        t_global_disable();
        t_period();
        t_mask_and_clear();
        t_reload_rewrite();
        t_chain();
        t_head_chain_ignored();
        t_set_clear_collide();
        t_count_readonly();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule